// File: doc/BRIEF.md
# MMU Translation-Buffer Register Port

This block is the register window a processor core uses to program and inspect its memory-management state. It keeps the process-ID register, the zone-protection register and the entry-index register. It also owns the translation-buffer storage: one tag word, one data word and one 8-bit owner ID per entry. Software selects an entry through the index register and then reads or writes its tag or data word. A write to the search register looks for the entry that covers a given address and stores the entry number, or a miss flag, in the index register.

The whole tag, data and owner-ID arrays are brought out on flat output vectors, together with the current process ID and zone-protection value, so that a separate translation unit can match addresses against them. Two configuration inputs set how much of the window is usable. One is the management level, which must be at least 2 for the window to work. The other is a 2-bit access setting: bit 0 allows reads of protected registers, and a value above 1 allows writes to the protected registers. Writes take effect on the clock edge. Read data is combinational from the current state.

Top module: `mmu_regfile`

## Requirements
- R1: Tag-word and data-word accesses target the entry given by bits 7:0 of the index register; higher index bits are ignored. An index of ENTRIES or above makes tag and data writes have no effect and makes tag and data reads return 0.
- R2: Writing the tag register stores the write data into the selected entry's tag and copies bits 7:0 of the process-ID register into that entry's owner ID.
- R3: A tag read returns the selected entry's tag and, at the clock edge, loads the process-ID register with that entry's owner ID, zero-extended. A data read returns the selected entry's data word and changes no state.
- R4: A search write masks the write data with 0xFFFFFC00 and, on a hit, loads the index register with the lowest matching entry number. An entry matches when all of the following hold. Tag bit 6 is set (valid). The address and the tag are equal above the page size, where tag bits 9:7 hold a code c and the page is 1 KiB times 4^c. The owner ID is 0 or equals process-ID bits 7:0. The entry is not excluded by its zone: data bits 7:4 hold a zone z, which selects zone-protection bits (31-2z):(30-2z), and a field of 00 excludes the entry when user_mode is 1.
- R5: A search that finds no entry sets bit 31 of the index register and keeps its other bits.
- R6: Writes to the process-ID, zone-protection and search registers have no effect unless the access setting is greater than 1.
- R7: Reads of the process-ID, zone-protection, tag and data registers return 0, and a tag read does not load the process-ID register, unless bit 0 of the access setting is 1.
- R8: When the management level is below 2 or the access setting is 0, every read returns 0 and every write has no effect.
- R9: Reset (synchronous, active high) clears the process-ID, zone-protection and index registers and all tag, data and owner-ID entries.
- R10: The register select is decoded as 0 process ID, 1 zone protection, 2 index, 3 data word, 4 tag word and 5 search. Selects 6 and 7 read 0 and ignore writes. The index register can be read and written whenever the window is enabled. rdata is 0 whenever rd_en is low.
- R11: Entry k's tag appears at tag_flat bits [32k+31:32k], its data word at the same bits of data_flat, and its owner ID at tid_flat bits [8k+7:8k].

Top module port order follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mmu_mode | input | 2 | Management level; 2 or more enables the window |
| cfg_tlb_access | input | 2 | Access setting: bit 0 allows protected reads, a value above 1 allows protected writes |
| user_mode | input | 1 | 1 when the core runs unprivileged; used by search |
| reg_sel | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, combinational |
| pid_o | output | 32 | Current process-ID register |
| zpr_o | output | 32 | Current zone-protection register |
| tag_flat | output | 32*ENTRIES | All tag words |
| data_flat | output | 32*ENTRIES | All data words |
| tid_flat | output | 8*ENTRIES | All owner IDs |

## Verification
The bench targets the side effects that are easy to miss. If the design skipped the owner-ID capture on a tag write, or the process-ID reload on a tag read, later searches would match the wrong entries. If a search miss overwrote the index register instead of setting bit 31, the old index bits would be lost. Searches are run with several page-size codes, overlapping entries (the lowest one must win), owner-ID mismatches and zone fields under both privilege levels. A wrong page mask or priority order would then return a different index. Each access setting is tried, along with a disabled window, out-of-range indices and index values with high bits set. A design that decoded too many index bits, or that left a gate open, would then show a change in the arrays or read data on the next cycle.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int WORD_W         = 32;
  localparam int OWNER_W        = 8;
  localparam int PAGE_BASE_LOG2 = 10;
  localparam int VALID_BIT      = 6;
  localparam int MISS_BIT       = 31;

  typedef enum logic [2:0] {
    SEL_PID    = 3'd0,
    SEL_ZONE   = 3'd1,
    SEL_INDEX  = 3'd2,
    SEL_DATA   = 3'd3,
    SEL_TAG    = 3'd4,
    SEL_SEARCH = 3'd5,
    SEL_RSV6   = 3'd6,
    SEL_RSV7   = 3'd7
  } reg_sel_e;

  // Mask that keeps the address bits above a page of 1 KiB * 4^code.
  function automatic logic [WORD_W-1:0] page_mask(input logic [2:0] code);
    page_mask = {WORD_W{1'b1}} << (PAGE_BASE_LOG2 + 2 * int'(code));
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tag_we,
  input  logic                        data_we,
  input  logic [7:0]                  widx,
  input  logic [31:0]                 wdata,
  input  logic [7:0]                  owner_in,
  output logic [ENTRIES*32-1:0]       tag_flat,
  output logic [ENTRIES*32-1:0]       data_flat,
  output logic [ENTRIES*8-1:0]        tid_flat
);
  generate
    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
      logic [31:0] tag_q;
      logic [31:0] data_q;
      logic [7:0]  own_q;
      logic        hit_k;

      // widx never equals an out-of-range entry number, so those writes drop
      assign hit_k = (widx == 8'(k));

      always_ff @(posedge clk) begin
        if (rst) begin
          tag_q  <= '0;
          data_q <= '0;
          own_q  <= '0;
        end else begin
          if (tag_we && hit_k) begin
            tag_q <= wdata;
            own_q <= owner_in;
          end
          if (data_we && hit_k) data_q <= wdata;
        end
      end

      assign tag_flat[k*32 +: 32]  = tag_q;
      assign data_flat[k*32 +: 32] = data_q;
      assign tid_flat[k*8 +: 8]    = own_q;
    end
  endgenerate
endmodule

// File: rtl/tlb_search_match.sv
module tlb_search_match
  import mmu_regs_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic [ENTRIES*32-1:0] tag_flat,
  input  logic [ENTRIES*4-1:0]  zone_flat,
  input  logic [ENTRIES*8-1:0]  tid_flat,
  input  logic [31:0]           addr,
  input  logic [7:0]            pid,
  input  logic [31:0]           zpr,
  input  logic                  user_mode,
  output logic                  hit,
  output logic [7:0]            hit_idx
);
  logic [ENTRIES-1:0] match;

  generate
    for (genvar k = 0; k < ENTRIES; k++) begin : g_cmp
      logic [31:0] tag_k;
      logic [31:0] mask_k;
      logic [7:0]  own_k;
      logic [3:0]  zsel_k;
      logic [1:0]  zfield_k;

      assign tag_k  = tag_flat[k*32 +: 32];
      assign own_k  = tid_flat[k*8 +: 8];
      assign zsel_k = zone_flat[k*4 +: 4];

      always_comb begin
        mask_k   = page_mask(tag_k[9:7]);
        zfield_k = zpr[30 - 2 * int'(zsel_k) +: 2];
        match[k] = tag_k[VALID_BIT]
                && ((addr & mask_k) == (tag_k & mask_k))
                && ((own_k == 8'd0) || (own_k == pid))
                && !((zfield_k == 2'b00) && user_mode);
      end
    end
  endgenerate

  // Lowest matching entry wins
  always_comb begin
    hit     = 1'b0;
    hit_idx = 8'd0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (match[k]) begin
        hit     = 1'b1;
        hit_idx = 8'(k);
      end
    end
  end
endmodule

// File: rtl/mmu_regfile.sv
module mmu_regfile
  import mmu_regs_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [1:0]            cfg_mmu_mode,
  input  logic [1:0]            cfg_tlb_access,
  input  logic                  user_mode,
  input  logic [2:0]            reg_sel,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [31:0]           wdata,
  output logic [31:0]           rdata,
  output logic [31:0]           pid_o,
  output logic [31:0]           zpr_o,
  output logic [ENTRIES*32-1:0] tag_flat,
  output logic [ENTRIES*32-1:0] data_flat,
  output logic [ENTRIES*8-1:0]  tid_flat
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [31:0] SEARCH_MASK = 32'hFFFF_FC00;

  reg_sel_e    sel;
  logic [31:0] pid_q, zpr_q, tlbx_q;
  logic        win_on, rd_ok, wr_ctl_ok, wr_go;
  logic [7:0]  sel_idx;
  logic        idx_ok;
  logic [IDX_W-1:0] ix;
  logic [31:0] tag_sel, data_sel;
  logic [7:0]  own_sel;
  logic        tag_we, data_we;
  logic        srch_hit;
  logic [7:0]  srch_idx;
  logic [ENTRIES*4-1:0] zone_flat;
  logic [31:0] rd_word;

  assign sel       = reg_sel_e'(reg_sel);
  assign win_on    = (cfg_mmu_mode >= 2'd2) && (cfg_tlb_access != 2'd0);
  assign rd_ok     = cfg_tlb_access[0];
  assign wr_ctl_ok = cfg_tlb_access[1];
  assign wr_go     = wr_en && win_on;

  assign sel_idx = tlbx_q[7:0];
  assign idx_ok  = (32'(sel_idx) < 32'(ENTRIES));
  assign ix      = sel_idx[IDX_W-1:0];

  assign tag_we  = wr_go && (sel == SEL_TAG);
  assign data_we = wr_go && (sel == SEL_DATA);

  tlb_entry_store #(.ENTRIES(ENTRIES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .tag_we   (tag_we),
    .data_we  (data_we),
    .widx     (sel_idx),
    .wdata    (wdata),
    .owner_in (pid_q[7:0]),
    .tag_flat (tag_flat),
    .data_flat(data_flat),
    .tid_flat (tid_flat)
  );

  generate
    for (genvar k = 0; k < ENTRIES; k++) begin : g_zone
      assign zone_flat[k*4 +: 4] = data_flat[k*32 + 4 +: 4];
    end
  endgenerate

  tlb_search_match #(.ENTRIES(ENTRIES)) u_search (
    .tag_flat (tag_flat),
    .zone_flat(zone_flat),
    .tid_flat (tid_flat),
    .addr     (wdata & SEARCH_MASK),
    .pid      (pid_q[7:0]),
    .zpr      (zpr_q),
    .user_mode(user_mode),
    .hit      (srch_hit),
    .hit_idx  (srch_idx)
  );

  assign tag_sel  = tag_flat[32*int'(ix) +: 32];
  assign data_sel = data_flat[32*int'(ix) +: 32];
  assign own_sel  = tid_flat[8*int'(ix) +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q  <= '0;
      zpr_q  <= '0;
      tlbx_q <= '0;
    end else if (wr_go) begin
      unique case (sel)
        SEL_PID:    if (wr_ctl_ok) pid_q <= wdata;
        SEL_ZONE:   if (wr_ctl_ok) zpr_q <= wdata;
        SEL_INDEX:  tlbx_q <= wdata;
        SEL_SEARCH: if (wr_ctl_ok) begin
          if (srch_hit) tlbx_q <= {24'd0, srch_idx};
          else          tlbx_q[MISS_BIT] <= 1'b1;
        end
        default: ;
      endcase
    end else if (rd_en && win_on && rd_ok && (sel == SEL_TAG) && idx_ok) begin
      pid_q <= {24'd0, own_sel};
    end
  end

  always_comb begin
    unique case (sel)
      SEL_PID:   rd_word = rd_ok ? pid_q : '0;
      SEL_ZONE:  rd_word = rd_ok ? zpr_q : '0;
      SEL_INDEX: rd_word = tlbx_q;
      SEL_DATA:  rd_word = (rd_ok && idx_ok) ? data_sel : '0;
      SEL_TAG:   rd_word = (rd_ok && idx_ok) ? tag_sel : '0;
      default:   rd_word = '0;
    endcase
  end

  assign rdata = (rd_en && win_on) ? rd_word : '0;
  assign pid_o = pid_q;
  assign zpr_o = zpr_q;
endmodule

// File: rtl/mmu_regfile_chk.sv
module mmu_regfile_chk #(
  parameter int ENTRIES = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic [1:0]           cfg_mmu_mode,
  input logic [1:0]           cfg_tlb_access,
  input logic [2:0]           reg_sel,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [31:0]          rdata,
  input logic [31:0]          pid_o,
  input logic [31:0]          zpr_o,
  input logic [31:0]          tlbx,
  input logic [ENTRIES*8-1:0] tid_flat
);
  logic       on;
  logic [7:0] own_at;

  assign on = (cfg_mmu_mode >= 2'd2) && (cfg_tlb_access != 2'd0);

  always_comb begin
    own_at = 8'd0;
    for (int k = 0; k < ENTRIES; k++)
      if (tlbx[7:0] == 8'(k)) own_at = tid_flat[k*8 +: 8];
  end

  // R9: one cycle after reset the control registers are zero
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (pid_o == 32'd0) && (zpr_o == 32'd0) && (tlbx == 32'd0));

  // R2: a tag write leaves the owner ID equal to the process ID it saw
  a_r2_owner_capture: assert property (@(posedge clk) disable iff (rst)
    (wr_en && on && reg_sel == 3'd4 && 32'(tlbx[7:0]) < 32'(ENTRIES))
      |=> own_at == $past(pid_o[7:0]));

  // R6: locked process-ID write leaves it unchanged
  a_r6_pid_locked: assert property (@(posedge clk) disable iff (rst)
    (wr_en && reg_sel == 3'd0 && !cfg_tlb_access[1]) |=> $stable(pid_o));

  // R5 / R4: a search either sets the miss flag keeping the rest, or lands in range
  a_r5_search_result: assert property (@(posedge clk) disable iff (rst)
    (wr_en && on && reg_sel == 3'd5 && cfg_tlb_access[1])
      |=> (tlbx[31] ? (tlbx[30:0] == $past(tlbx[30:0])) : (tlbx < 32'(ENTRIES))));

  // R7: protected reads are zero without read permission
  a_r7_read_gate: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !cfg_tlb_access[0] && (reg_sel == 3'd0 || reg_sel == 3'd1 ||
     reg_sel == 3'd3 || reg_sel == 3'd4)) |-> rdata == 32'd0);

  // R8: a disabled window reads zero and keeps its registers
  a_r8_off_read: assert property (@(posedge clk) disable iff (rst)
    !on |-> rdata == 32'd0);
  a_r8_off_hold: assert property (@(posedge clk) disable iff (rst)
    (!on && (wr_en || rd_en)) |=> $stable(pid_o) && $stable(zpr_o) && $stable(tlbx));
endmodule

bind mmu_regfile mmu_regfile_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .cfg_mmu_mode  (cfg_mmu_mode),
  .cfg_tlb_access(cfg_tlb_access),
  .reg_sel       (reg_sel),
  .wr_en         (wr_en),
  .rd_en         (rd_en),
  .rdata         (rdata),
  .pid_o         (pid_o),
  .zpr_o         (zpr_o),
  .tlbx          (tlbx_q),
  .tid_flat      (tid_flat)
);

// File: tb/tb_mmu_regfile.sv
module tb_mmu_regfile;
  localparam int N = 16;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      cfg_mmu_mode = 2'd2;
  logic [1:0]      cfg_tlb_access = 2'd3;
  logic            user_mode = 1'b0;
  logic [2:0]      reg_sel = 3'd0;
  logic            wr_en = 1'b0;
  logic            rd_en = 1'b0;
  logic [31:0]     wdata = 32'd0;
  logic [31:0]     rdata, pid_o, zpr_o;
  logic [N*32-1:0] tag_flat, data_flat;
  logic [N*8-1:0]  tid_flat;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // reference state
  logic [31:0] m_tag [N];
  logic [31:0] m_data[N];
  logic [7:0]  m_tid [N];
  logic [31:0] m_pid, m_zpr, m_idx;

  always #10 clk = ~clk;

  mmu_regfile #(.ENTRIES(N)) dut (
    .clk(clk), .rst(rst), .cfg_mmu_mode(cfg_mmu_mode), .cfg_tlb_access(cfg_tlb_access),
    .user_mode(user_mode), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .pid_o(pid_o), .zpr_o(zpr_o),
    .tag_flat(tag_flat), .data_flat(data_flat), .tid_flat(tid_flat)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic bit m_on();
    return (cfg_mmu_mode >= 2) && (cfg_tlb_access != 0);
  endfunction

  function automatic logic [31:0] m_read();
    int i = int'(m_idx[7:0]);
    if (!(rd_en && m_on())) return 32'd0;
    case (reg_sel)
      3'd0: return cfg_tlb_access[0] ? m_pid : 32'd0;
      3'd1: return cfg_tlb_access[0] ? m_zpr : 32'd0;
      3'd2: return m_idx;
      3'd3: return (cfg_tlb_access[0] && i < N) ? m_data[i] : 32'd0;
      3'd4: return (cfg_tlb_access[0] && i < N) ? m_tag[i] : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  task automatic m_search(input logic [31:0] a_in);
    logic [31:0] a = a_in & 32'hFFFF_FC00;
    for (int i = 0; i < N; i++) begin
      int sh = 10 + 2 * int'(m_tag[i][9:7]);
      int zs = int'(m_data[i][7:4]);
      int zf = int'((m_zpr >> (30 - 2 * zs)) & 32'd3);
      if (m_tag[i][6] && ((a >> sh) == (m_tag[i] >> sh)) &&
          (m_tid[i] == 0 || m_tid[i] == m_pid[7:0]) && !(zf == 0 && user_mode)) begin
        m_idx = 32'(i);
        return;
      end
    end
    m_idx[31] = 1'b1;
  endtask

  task automatic m_step();
    int i = int'(m_idx[7:0]);
    if (rst) begin
      m_pid = 0; m_zpr = 0; m_idx = 0;
      for (int k = 0; k < N; k++) begin m_tag[k] = 0; m_data[k] = 0; m_tid[k] = 0; end
    end else if (wr_en && m_on()) begin
      case (reg_sel)
        3'd0: if (cfg_tlb_access > 1) m_pid = wdata;
        3'd1: if (cfg_tlb_access > 1) m_zpr = wdata;
        3'd2: m_idx = wdata;
        3'd3: if (i < N) m_data[i] = wdata;
        3'd4: if (i < N) begin m_tag[i] = wdata; m_tid[i] = m_pid[7:0]; end
        3'd5: if (cfg_tlb_access > 1) m_search(wdata);
        default: ;
      endcase
    end else if (rd_en && m_on() && cfg_tlb_access[0] && reg_sel == 3'd4 && i < N) begin
      m_pid = {24'd0, m_tid[i]};
    end
  endtask

  task automatic check_state(input string req);
    check(req, "pid", pid_o, m_pid);
    check(req, "zpr", zpr_o, m_zpr);
    for (int k = 0; k < N; k++) begin
      check("R11", $sformatf("%s tag[%0d]", req, k), tag_flat[k*32 +: 32], m_tag[k]);
      check("R11", $sformatf("%s data[%0d]", req, k), data_flat[k*32 +: 32], m_data[k]);
      check("R11", $sformatf("%s tid[%0d]", req, k), 32'(tid_flat[k*8 +: 8]), 32'(m_tid[k]));
    end
  endtask

  // one access: compare read before the edge, state after it
  task automatic op(input string req, input logic [2:0] s, input bit w, input bit r,
                    input logic [31:0] d);
    reg_sel = s; wr_en = w; rd_en = r; wdata = d;
    #2;
    check(req, "rdata", rdata, m_read());
    @(posedge clk);
    m_step();
    @(negedge clk);
    check_state(req);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic wr(input string req, input logic [2:0] s, input logic [31:0] d);
    op(req, s, 1'b1, 1'b0, d);
  endtask

  task automatic rd(input string req, input logic [2:0] s);
    op(req, s, 1'b0, 1'b1, 32'd0);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(posedge clk);
    m_step();
    @(negedge clk);
    rst = 1'b0;
    check_state("R9");
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    rd("R9", 3'd2);
    rd("R9", 3'd0);

    // populate entries
    wr("R6", 3'd0, 32'h0000_0015);
    wr("R10", 3'd2, 32'd2);
    wr("R2", 3'd4, 32'h0000_40C0);        // 4 KiB page at 0x4000, owner 0x15
    wr("R11", 3'd3, 32'h1234_5000);       // zone 0
    wr("R6", 3'd0, 32'd0);
    wr("R10", 3'd2, 32'd5);
    wr("R2", 3'd4, 32'h0010_0040);        // 1 KiB page at 0x100000, global
    wr("R11", 3'd3, 32'h0000_0010);       // zone 1
    wr("R10", 3'd2, 32'd7);
    wr("R2", 3'd4, 32'h0010_0040);        // duplicate of entry 5
    wr("R10", 3'd2, 32'd9);
    wr("R2", 3'd4, 32'h0100_03C0);        // 16 MiB page at 0x1000000
    wr("R10", 3'd2, 32'h0000_0103);       // high bits ignored -> entry 3
    wr("R1", 3'd3, 32'hDEAD_BEEF);
    wr("R10", 3'd2, 32'd20);              // out of range
    wr("R1", 3'd4, 32'hFFFF_FFFF);
    wr("R1", 3'd3, 32'h1111_1111);
    rd("R1", 3'd4);
    rd("R1", 3'd3);

    // reads with owner-ID reload
    wr("R6", 3'd0, 32'h0000_0033);
    wr("R10", 3'd2, 32'd2);
    rd("R3", 3'd4);
    rd("R3", 3'd3);
    rd("R3", 3'd0);

    // searches
    wr("R4", 3'd5, 32'h0000_4ABC);
    rd("R4", 3'd2);
    wr("R4", 3'd5, 32'h0010_0200);        // entries 5 and 7 match, 5 wins
    rd("R4", 3'd2);
    wr("R4", 3'd5, 32'h01AB_CDEF);
    rd("R4", 3'd2);
    wr("R6", 3'd0, 32'h0000_0022);
    wr("R5", 3'd5, 32'h0000_4ABC);        // owner mismatch -> miss
    rd("R5", 3'd2);
    wr("R5", 3'd5, 32'h0800_0000);
    rd("R5", 3'd2);
    user_mode = 1'b1;
    wr("R4", 3'd5, 32'h0010_0200);        // zone field 00, user -> miss
    rd("R4", 3'd2);
    wr("R6", 3'd1, 32'h1000_0000);        // zone 1 field = 01
    wr("R4", 3'd5, 32'h0010_0200);
    rd("R4", 3'd2);
    user_mode = 1'b0;

    // access setting 1: reads only
    cfg_tlb_access = 2'd1;
    wr("R6", 3'd0, 32'h0000_0077);
    wr("R6", 3'd1, 32'hFFFF_FFFF);
    wr("R6", 3'd5, 32'h0000_4000);
    rd("R6", 3'd2);
    wr("R10", 3'd2, 32'd4);
    wr("R2", 3'd4, 32'h0020_0040);
    rd("R7", 3'd1);

    // access setting 2: protected reads blocked
    cfg_tlb_access = 2'd2;
    rd("R7", 3'd0);
    rd("R7", 3'd1);
    rd("R7", 3'd3);
    rd("R7", 3'd4);
    rd("R7", 3'd2);
    wr("R6", 3'd0, 32'h0000_0044);

    // disabled window
    cfg_tlb_access = 2'd0;
    rd("R8", 3'd2);
    wr("R8", 3'd2, 32'd1);
    wr("R8", 3'd4, 32'h0000_0040);
    cfg_tlb_access = 2'd3;
    cfg_mmu_mode = 2'd1;
    rd("R8", 3'd0);
    wr("R8", 3'd0, 32'h0000_0099);
    wr("R8", 3'd3, 32'h5555_5555);
    cfg_mmu_mode = 2'd2;

    // reserved selects
    wr("R10", 3'd6, 32'hFFFF_FFFF);
    rd("R10", 3'd6);
    rd("R10", 3'd7);
    op("R10", 3'd2, 1'b0, 1'b0, 32'd0);   // no strobe -> rdata 0

    do_reset();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        repeat (100000) @(posedge clk);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: got timeout expected completion");
      end
      wait (done);
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule